// File: doc/BRIEF.md
# PLL Divider Source Selector and Reset Sequencer

This block chooses where the clock PLL takes its feedback divider N and its reference divider M from. It also issues reset pulses to the PLL and to the downstream clock unit. Three sources exist:

- a pair of software-written divider registers, used when a parallel host bus is the access path;
- an 11-bit strap bus sampled from board pins, used when a serial host interface is the access path;
- a hard-wired fixed setting of N = 33, M = 0, which overrides both whenever variable-frequency operation is switched off.

The block keeps one registered copy of the divider pair that is currently in effect, and it drives the outputs from that copy. When that pair takes a new value, the PLL reset is raised for a fixed number of cycles, whatever caused the change. A write, a strap change or a mode switch that leaves the effective pair as it was causes no PLL reset. A change of line standard on any channel restarts only the clock unit. Every PLL reset also restarts the clock unit.

Strap pins are asynchronous, so they pass through a two-stage synchronizer before they are compared. While the block reset is high, the synchronizer and the effective copy keep following their inputs. As a result, the straps present during reset become the initial configuration without an extra pulse after release.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: In parallel mode with `var_freq_en` = 1, `div_n`/`div_m` follow the divider registers. A write (`wr_div_n` or `wr_div_m` high for one cycle) that changes the effective pair produces a PLL reset pulse. A write of the value already held produces none.
- R2: In serial mode with `var_freq_en` = 1, `div_n` = `strap[5:0]` and `div_m` = `strap[10:6]`. Any strap change that alters the pair produces a PLL reset pulse.
- R3: In serial mode, divider register writes are dropped: they produce no PLL reset, and the register keeps its old value. That old value shows once parallel mode is selected again. The reset value of the registers is N = 33, M = 0.
- R4: With `var_freq_en` = 0, `div_n` = 33 and `div_m` = 0. Register writes and strap changes then have no effect on the outputs and raise no PLL reset.
- R5: While `rst` is high, `pll_rst` and `clk_unit_rst` are high, and the outputs already show the configuration selected by the inputs present during reset. After release, both resets stay high for PULSE_LEN-1 further cycles (3 with defaults) and then fall, unless a trigger occurs.
- R6: A change of any bit of `line_t1` produces a clock-unit reset pulse and no PLL reset.
- R7: A single trigger gives a reset pulse of exactly PULSE_LEN cycles (4 with defaults).
- R8: Whenever `pll_rst` is high, `clk_unit_rst` is high.
- R9: Leaving variable mode while the effective pair is already 33/0 gives no PLL reset. When the pair differs, the same step gives a pulse.
- R10: `if_mode` values 0 and 1 select the parallel (register) source; values 2 and 3 select the serial (strap) source.
- R11: A new trigger that arrives while a pulse is active restarts the full PULSE_LEN count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| if_mode | input | 2 | Host interface selector: bit 1 = 1 means serial |
| var_freq_en | input | 1 | 1 = variable dividers in use, 0 = fixed 33/0 |
| wr_div_n | input | 1 | One-cycle write strobe for the N register |
| wr_div_n_data | input | 6 | N write data |
| wr_div_m | input | 1 | One-cycle write strobe for the M register |
| wr_div_m_data | input | 5 | M write data |
| strap | input | 11 | Asynchronous strap pins: [5:0] N, [10:6] M |
| line_t1 | input | 8 | Per-channel line standard, 1 = T1/J1, 0 = E1 |
| div_n | output | 6 | Effective N divider |
| div_m | output | 5 | Effective M divider |
| pll_rst | output | 1 | PLL reset pulse |
| clk_unit_rst | output | 1 | Clock-unit reset pulse |

## Verification
Each trigger reaches the outputs after a known number of clock edges:

| Trigger | Edges until outputs and pulses change |
|---|---|
| Change of `if_mode` or `var_freq_en` | 1 edge (the edge that samples it) |
| Change of `line_t1` | 1 edge (the edge that samples it) |
| Register write | 2 edges (register update, then effective copy) |
| Strap change | 3 edges (two synchronizer stages, then the effective copy) |

A behavioural reference model in the bench advances at every rising edge. Its outputs are compared at the following falling edge, so each compare lands after the design's registers have settled. The directed checks count pulse cycles over windows wide enough to cover the longest of these latencies. This makes the expected counts (0, 3, 4) independent of where the pulse starts inside the window. The restart case spaces its two writes so that only a reloaded counter can still be high at the end of the window.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int N_W      = 6;
    localparam int M_W      = 5;
    localparam int STRAP_W  = N_W + M_W;
    localparam int N_FIXED  = 33;
    localparam int M_FIXED  = 0;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } div_cfg_t;

    typedef enum logic [1:0] {
        SRC_FIXED = 2'd0,
        SRC_REGS  = 2'd1,
        SRC_STRAP = 2'd2
    } cfg_src_t;

    function automatic div_cfg_t fixed_cfg();
        div_cfg_t c;
        c.n = N_W'(N_FIXED);
        c.m = M_W'(M_FIXED);
        return c;
    endfunction

    function automatic div_cfg_t strap_decode(input logic [STRAP_W-1:0] s);
        div_cfg_t c;
        c.n = s[N_W-1:0];
        c.m = s[STRAP_W-1:N_W];
        return c;
    endfunction

    function automatic cfg_src_t pick_source(input logic [1:0] mode, input logic var_en);
        cfg_src_t r;
        if (!var_en)
            r = SRC_FIXED;
        else if (mode[1])
            r = SRC_STRAP;
        else
            r = SRC_REGS;
        return r;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/div_regs.sv
module div_regs
    import pll_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           wr_n,
    input  logic [N_W-1:0] n_data,
    input  logic           wr_m,
    input  logic [M_W-1:0] m_data,
    output div_cfg_t       cfg
);
    div_cfg_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= fixed_cfg();
        end else if (accept) begin
            if (wr_n) held.n <= n_data;
            if (wr_m) held.m <= m_data;
        end
    end

    assign cfg = held;
endmodule

// File: rtl/cfg_select.sv
module cfg_select
    import pll_cfg_pkg::*;
(
    input  logic     clk,
    input  cfg_src_t src,
    input  div_cfg_t reg_cfg,
    input  div_cfg_t strap_cfg,
    output div_cfg_t eff_cfg,
    output logic     changed
);
    div_cfg_t next_cfg;
    div_cfg_t eff_q;

    always_comb begin
        unique case (src)
            SRC_REGS:  next_cfg = reg_cfg;
            SRC_STRAP: next_cfg = strap_cfg;
            default:   next_cfg = fixed_cfg();
        endcase
    end

    // Tracks also during reset so the configuration at release is the initial one.
    always_ff @(posedge clk) begin
        eff_q <= next_cfg;
    end

    assign changed = (next_cfg != eff_q);
    assign eff_cfg = eff_q;
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || trig)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
    import pll_cfg_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         if_mode,
    input  logic               var_freq_en,
    input  logic               wr_div_n,
    input  logic [N_W-1:0]     wr_div_n_data,
    input  logic               wr_div_m,
    input  logic [M_W-1:0]     wr_div_m_data,
    input  logic [STRAP_W-1:0] strap,
    input  logic [NUM_CH-1:0]  line_t1,
    output logic [N_W-1:0]     div_n,
    output logic [M_W-1:0]     div_m,
    output logic               pll_rst,
    output logic               clk_unit_rst
);
    cfg_src_t           src;
    div_cfg_t           reg_cfg;
    div_cfg_t           strap_cfg;
    div_cfg_t           eff_cfg;
    logic [STRAP_W-1:0] strap_s;
    logic               cfg_changed;
    logic [NUM_CH-1:0]  line_q;
    logic [NUM_CH-1:0]  line_flip;
    logic               line_changed;

    assign src = pick_source(if_mode, var_freq_en);

    bit_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_strap_sync (
        .clk (clk),
        .d   (strap),
        .q   (strap_s)
    );

    assign strap_cfg = strap_decode(strap_s);

    div_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .accept (src == SRC_REGS),
        .wr_n   (wr_div_n),
        .n_data (wr_div_n_data),
        .wr_m   (wr_div_m),
        .m_data (wr_div_m_data),
        .cfg    (reg_cfg)
    );

    cfg_select u_sel (
        .clk       (clk),
        .src       (src),
        .reg_cfg   (reg_cfg),
        .strap_cfg (strap_cfg),
        .eff_cfg   (eff_cfg),
        .changed   (cfg_changed)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_line
            always_ff @(posedge clk) begin
                line_q[ch] <= line_t1[ch];
            end
            assign line_flip[ch] = line_q[ch] ^ line_t1[ch];
        end
    endgenerate

    assign line_changed = |line_flip;

    pulse_gen #(.LEN(PULSE_LEN)) u_pll_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (cfg_changed),
        .pulse (pll_rst)
    );

    pulse_gen #(.LEN(PULSE_LEN)) u_cu_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (cfg_changed | line_changed),
        .pulse (clk_unit_rst)
    );

    assign div_n = eff_cfg.n;
    assign div_m = eff_cfg.m;
endmodule

// File: rtl/pll_cfg_ctrl_chk.sv
module pll_cfg_ctrl_chk
    import pll_cfg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              var_freq_en,
    input logic [NUM_CH-1:0] line_t1,
    input logic [N_W-1:0]    div_n,
    input logic [M_W-1:0]    div_m,
    input logic              pll_rst,
    input logic              clk_unit_rst
);
    AST_FIXED_VALUES: assert property (@(posedge clk) disable iff (rst)
        !var_freq_en |=> (div_n == N_W'(N_FIXED) && div_m == M_W'(M_FIXED))); // R4

    AST_PLL_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
        pll_rst |-> clk_unit_rst); // R8

    AST_CHANGE_PULSES: assert property (@(posedge clk) disable iff (rst)
        (div_n != $past(div_n) || div_m != $past(div_m)) |-> pll_rst); // R1

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_rst) |-> (div_n != $past(div_n) || div_m != $past(div_m))); // R9

    AST_LINE_CLK: assert property (@(posedge clk) disable iff (rst)
        (line_t1 != $past(line_t1)) |=> clk_unit_rst); // R6
endmodule

bind pll_cfg_ctrl pll_cfg_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .var_freq_en  (var_freq_en),
    .line_t1      (line_t1),
    .div_n        (div_n),
    .div_m        (div_m),
    .pll_rst      (pll_rst),
    .clk_unit_rst (clk_unit_rst)
);

// File: tb/tb_pll_cfg_ctrl.sv
module tb_pll_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  if_mode = 2'd2;
    logic        var_freq_en = 1'b1;
    logic        wr_div_n = 1'b0;
    logic [5:0]  wr_div_n_data = '0;
    logic        wr_div_m = 1'b0;
    logic [4:0]  wr_div_m_data = '0;
    logic [10:0] strap = {5'd0, 6'd33};
    logic [7:0]  line_t1 = '0;
    logic [5:0]  div_n;
    logic [4:0]  div_m;
    logic        pll_rst;
    logic        clk_unit_rst;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    pll_cfg_ctrl dut (
        .clk(clk), .rst(rst), .if_mode(if_mode), .var_freq_en(var_freq_en),
        .wr_div_n(wr_div_n), .wr_div_n_data(wr_div_n_data),
        .wr_div_m(wr_div_m), .wr_div_m_data(wr_div_m_data),
        .strap(strap), .line_t1(line_t1), .div_n(div_n), .div_m(div_m),
        .pll_rst(pll_rst), .clk_unit_rst(clk_unit_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int q_strap[$] = '{0, 0};
    int m_rn = 33, m_rm = 0, m_en = 33, m_em = 0, m_pc = 4, m_cc = 4, m_line = 0;

    always @(posedge clk) begin
        int nn, nm, sel, s2;
        bit trig, lc;
        s2 = q_strap[0];
        if (!var_freq_en) sel = 0;
        else if (if_mode >= 2) sel = 2;
        else sel = 1;
        if (sel == 0) begin nn = 33; nm = 0; end
        else if (sel == 1) begin nn = m_rn; nm = m_rm; end
        else begin nn = s2 % 64; nm = (s2 / 64) % 32; end
        if (rst) begin
            m_rn = 33; m_rm = 0; m_pc = 4; m_cc = 4;
        end else begin
            trig = (nn != m_en) || (nm != m_em);
            lc   = (int'(line_t1) != m_line);
            if (sel == 1) begin
                if (wr_div_n) m_rn = int'(wr_div_n_data);
                if (wr_div_m) m_rm = int'(wr_div_m_data);
            end
            m_pc = trig ? 4 : (m_pc > 0 ? m_pc - 1 : 0);
            m_cc = (trig || lc) ? 4 : (m_cc > 0 ? m_cc - 1 : 0);
        end
        m_line = int'(line_t1);
        m_en = nn;
        m_em = nm;
        void'(q_strap.pop_front());
        q_strap.push_back(int'(strap));
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 model div_n", int'(div_n), m_en);
            chk("R2 model div_m", int'(div_m), m_em);
            chk("R7 model pll_rst", int'(pll_rst), int'(m_pc > 0));
            chk("R8 model clk_unit_rst", int'(clk_unit_rst), int'(m_cc > 0));
        end
    end

    task automatic count_pulses(input int ncyc, output int np, output int nc);
        np = 0; nc = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            np += int'(pll_rst);
            nc += int'(clk_unit_rst);
        end
    endtask

    task automatic write_n(input int d);
        wr_div_n = 1'b1; wr_div_n_data = 6'(d);
        @(negedge clk);
        wr_div_n = 1'b0;
    endtask

    task automatic write_m(input int d);
        wr_div_m = 1'b1; wr_div_m_data = 5'(d);
        @(negedge clk);
        wr_div_m = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int np, nc;
        repeat (4) @(negedge clk);
        chk("R5 pll_rst in reset", int'(pll_rst), 1);
        chk("R5 clk_unit_rst in reset", int'(clk_unit_rst), 1);
        chk("R5 initial div_n", int'(div_n), 33);
        rst = 1'b0;
        count_pulses(8, np, nc);
        chk("R5 pll cycles after release", np, 3);
        chk("R5 clk cycles after release", nc, 3);

        strap = {5'd3, 6'd20};
        count_pulses(10, np, nc);
        chk("R2 strap pulse", np, 4);
        chk("R8 clk with pll", nc, 4);
        chk("R2 div_n", int'(div_n), 20);
        chk("R2 div_m", int'(div_m), 3);

        if_mode = 2'd3;
        count_pulses(6, np, nc);
        chk("R10 mode 3 serial", np, 0);

        write_n(50);
        count_pulses(8, np, nc);
        chk("R3 write in serial no pulse", np, 0);
        chk("R3 div_n kept", int'(div_n), 20);

        if_mode = 2'd0;
        count_pulses(8, np, nc);
        chk("R1 source switch pulse", np, 4);
        chk("R3 register not written", int'(div_n), 33);
        chk("R3 register m", int'(div_m), 0);

        write_n(40);
        count_pulses(8, np, nc);
        chk("R7 write pulse length", np, 4);
        chk("R1 div_n written", int'(div_n), 40);
        write_n(40);
        count_pulses(8, np, nc);
        chk("R1 same value no pulse", np, 0);
        write_m(7);
        count_pulses(8, np, nc);
        chk("R1 m write pulse", np, 4);
        chk("R1 div_m written", int'(div_m), 7);

        if_mode = 2'd1;
        count_pulses(6, np, nc);
        chk("R10 mode 1 parallel no pulse", np, 0);
        write_n(12);
        count_pulses(8, np, nc);
        chk("R10 mode 1 write pulse", np, 4);
        chk("R10 mode 1 div_n", int'(div_n), 12);

        write_n(10);
        @(negedge clk);
        write_n(11);
        count_pulses(10, np, nc);
        chk("R11 restart tail", np, 4);
        chk("R11 div_n", int'(div_n), 11);

        var_freq_en = 1'b0;
        count_pulses(8, np, nc);
        chk("R9 enter fixed differs pulse", np, 4);
        chk("R4 fixed n", int'(div_n), 33);
        chk("R4 fixed m", int'(div_m), 0);
        write_n(5);
        count_pulses(8, np, nc);
        chk("R4 write ignored pulse", np, 0);
        chk("R4 write ignored n", int'(div_n), 33);
        if_mode = 2'd2;
        strap = {5'd1, 6'd1};
        count_pulses(8, np, nc);
        chk("R4 strap ignored pulse", np, 0);
        chk("R4 strap ignored n", int'(div_n), 33);

        if_mode = 2'd0;
        var_freq_en = 1'b1;
        count_pulses(8, np, nc);
        chk("R4 registers unchanged by fixed-mode write", int'(div_n), 11);
        write_n(33);
        count_pulses(8, np, nc);
        write_m(0);
        count_pulses(8, np, nc);
        var_freq_en = 1'b0;
        count_pulses(8, np, nc);
        chk("R9 enter fixed equal no pulse", np, 0);

        line_t1 = 8'h04;
        count_pulses(8, np, nc);
        chk("R6 line change pll", np, 0);
        chk("R6 line change clk", nc, 4);

        rst = 1'b1;
        if_mode = 2'd2;
        var_freq_en = 1'b1;
        strap = {5'd9, 6'd17};
        repeat (4) @(negedge clk);
        chk("R5 strap initial n", int'(div_n), 17);
        chk("R5 strap initial m", int'(div_m), 9);
        rst = 1'b0;
        count_pulses(8, np, nc);
        chk("R5 no extra pulse", np, 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule